// File: doc/BRIEF.md
# Digital One-Shot Pulse Generator

This block is a clocked one-shot. It replaces a resistor-capacitor monostable with a down-counter. It watches three asynchronous control pins: an active-low trigger, an active-high trigger and an active-low clear. When it sees a qualifying transition on one of these pins, it drives a single high pulse on `q_o`. The length of that pulse is a whole number of clock cycles, taken from the `dur_i` input.

Each of the three pins is brought into the clock domain by its own two-stage synchronizer. Edges are found by comparing the synchronized value with the value from the previous cycle.

There are three ways to start a pulse:
- a falling edge on the active-low trigger;
- a rising edge on the active-high trigger;
- a rising edge on the clear pin, provided both triggers are already in their enabling state.

Holding the clear pin low keeps the output idle. Taking it low during a pulse ends the pulse early. Once a pulse is running, further triggers do not extend it.

Top module: `pulse_oneshot`

## Requirements
- R1: A rising edge on `trig_i` while `trig_n_i` is low and `clr_n_i` is high starts a pulse.
- R2: A falling edge on `trig_n_i` while `trig_i` is high and `clr_n_i` is high starts a pulse. A rising edge on `trig_n_i` starts nothing.
- R3: A rising edge on `clr_n_i` while `trig_n_i` is low and `trig_i` is high starts a pulse.
- R4: While the synchronized `clr_n_i` is low, `q_o` is 0, whatever the trigger pins do.
- R5: Taking `clr_n_i` low during a pulse forces `q_o` low, cutting the pulse short.
- R6: With `trig_n_i` held high, or with `trig_i` held low, and no qualifying edge, `q_o` stays 0.
- R7: `q_n_o` is the inverse of `q_o` in every cycle.
- R8: A pulse keeps `q_o` high for exactly `dur_i` consecutive cycles. `dur_i` is sampled on the clock edge on which `q_o` rises. A `dur_i` of 0 gives a pulse of one cycle.
- R9: Qualifying edges that arrive while a pulse runs (other than in its final cycle) are ignored. They neither lengthen the pulse nor cause a later pulse.
- R10: A pin change sampled on clock edge k takes effect on `q_o` after clock edge k+2. This applies both when the change starts a pulse and when a low `clr_n_i` ends one.
- R11: While `rst` is high on a clock edge, the block returns to idle (`q_o`=0, `q_n_o`=1), and every internal history is set as if the pins were idle.
- R12: A qualifying edge that is detected in the final cycle of a pulse is accepted. `q_o` then stays high without a gap for a fresh `dur_i` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_n_i | input | 1 | Asynchronous trigger, fires on a falling edge |
| trig_i | input | 1 | Asynchronous trigger, fires on a rising edge |
| clr_n_i | input | 1 | Asynchronous clear, active low; its rising edge can also trigger |
| dur_i | input | DUR_W | Pulse length in clock cycles (0 is treated as 1) |
| q_o | output | 1 | Pulse output, high while a pulse runs |
| q_n_o | output | 1 | Complement of `q_o` |

## Verification
The bench builds the block with the default `DUR_W` of 16 and `SYNC_STAGES` of 2, so the fixed latency from pin to output is three edges. It drives `dur_i` only with small values, from 0 to 20. This keeps pulse ends, early clears, the zero-to-one clamp and a trigger landing on the last cycle of a pulse all within a few cycles of each other. A randomized phase mixes all three pins with short durations. In that phase, triggers that land inside a running pulse, clears that overlap a trigger, and back-to-back pulses occur many times.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Default width of the duration input.
    localparam int unsigned OS_DUR_W = 16;

    // Control pins, bundled as they travel through the synchronizer.
    typedef struct packed {
        logic trig_n;   // fires on a falling edge
        logic trig;     // fires on a rising edge
        logic clr_n;    // clear, active low
    } os_pins_t;

    // Value that means "nothing happening": used as the reset value for
    // every sampled copy of the pins, so that leaving reset creates no edge.
    localparam os_pins_t OS_PINS_IDLE = '{trig_n: 1'b1, trig: 1'b0, clr_n: 1'b1};

    // One flag per trigger path.
    typedef struct packed {
        logic b_rise;
        logic a_fall;
        logic c_rise;
    } os_cause_t;

    typedef enum logic [1:0] {
        OS_IDLE = 2'd0,
        OS_RUN  = 2'd1
    } os_state_t;

    function automatic logic os_any(input os_cause_t c);
        return c.b_rise | c.a_fall | c.c_rise;
    endfunction

endpackage

// File: rtl/os_sync.sv
module os_sync #(
    parameter int unsigned   W      = 3,
    parameter int unsigned   STAGES = 2,
    parameter logic [W-1:0]  INIT   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    localparam int unsigned LAST = STAGES - 1;

    // stage_q[0] captures the raw pins; stage_q[LAST] is the synchronized value.
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= INIT;
            end
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[LAST];

endmodule

// File: rtl/os_trigger.sv
module os_trigger
    import oneshot_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  os_pins_t cur_i,
    output logic     fire_o
);

    os_pins_t  prev_q;
    os_cause_t cause;

    // Synchronized pins one cycle ago; reset to idle so that no edge
    // is seen on the cycle after reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= OS_PINS_IDLE;
        end else begin
            prev_q <= cur_i;
        end
    end

    always_comb begin
        cause        = '0;
        // Active-high trigger rising, with the active-low trigger enabling.
        cause.b_rise = cur_i.clr_n && !cur_i.trig_n && cur_i.trig && !prev_q.trig;
        // Active-low trigger falling, with the active-high trigger enabling.
        cause.a_fall = cur_i.clr_n && cur_i.trig && !cur_i.trig_n && prev_q.trig_n;
        // Clear released while both triggers are already enabling.
        cause.c_rise = cur_i.clr_n && !prev_q.clr_n && !cur_i.trig_n && cur_i.trig;
    end

    assign fire_o = os_any(cause);

endmodule

// File: rtl/os_timer.sv
module os_timer
    import oneshot_pkg::*;
#(
    parameter int unsigned DUR_W = OS_DUR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire_i,
    input  logic             clr_n_i,
    input  logic [DUR_W-1:0] dur_i,
    output logic             q_o
);

    localparam logic [DUR_W-1:0] ONE = {{(DUR_W-1){1'b0}}, 1'b1};

    os_state_t        state_q;
    logic [DUR_W-1:0] rem_q;      // cycles still to run, counting the current one
    logic [DUR_W-1:0] dur_eff;
    logic             accept;
    logic             last_cyc;

    assign dur_eff  = (dur_i == '0) ? ONE : dur_i;
    assign last_cyc = (state_q == OS_RUN) && (rem_q == ONE);
    // A new start is taken when idle, or in the final cycle of a running pulse.
    assign accept   = (state_q == OS_IDLE) || last_cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OS_IDLE;
            rem_q   <= '0;
        end else if (!clr_n_i) begin
            state_q <= OS_IDLE;
            rem_q   <= '0;
        end else if (fire_i && accept) begin
            state_q <= OS_RUN;
            rem_q   <= dur_eff;
        end else if (last_cyc) begin
            state_q <= OS_IDLE;
            rem_q   <= '0;
        end else if (state_q == OS_RUN) begin
            rem_q   <= rem_q - ONE;
        end
    end

    assign q_o = (state_q == OS_RUN);

endmodule

// File: rtl/pulse_oneshot.sv
module pulse_oneshot
    import oneshot_pkg::*;
#(
    parameter int unsigned DUR_W       = OS_DUR_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_n_i,
    input  logic             trig_i,
    input  logic             clr_n_i,
    input  logic [DUR_W-1:0] dur_i,
    output logic             q_o,
    output logic             q_n_o
);

    localparam int unsigned PIN_W = $bits(os_pins_t);

    os_pins_t         pins_raw;
    os_pins_t         pins_s;
    logic [PIN_W-1:0] pins_vec;
    logic             fire;
    logic             clr_s;
    logic             q;

    assign pins_raw = '{trig_n: trig_n_i, trig: trig_i, clr_n: clr_n_i};

    os_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES),
        .INIT   (OS_PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pins_raw),
        .q_o (pins_vec)
    );

    assign pins_s = os_pins_t'(pins_vec);
    assign clr_s  = pins_s.clr_n;

    os_trigger u_trigger (
        .clk    (clk),
        .rst    (rst),
        .cur_i  (pins_s),
        .fire_o (fire)
    );

    os_timer #(
        .DUR_W (DUR_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .fire_i  (fire),
        .clr_n_i (clr_s),
        .dur_i   (dur_i),
        .q_o     (q)
    );

    assign q_o   = q;
    assign q_n_o = ~q;

endmodule

// File: rtl/oneshot_checker.sv
module oneshot_checker (
    input logic clk,
    input logic rst,
    input logic fire,
    input logic clr_s,
    input logic q_o,
    input logic q_n_o
);

    logic rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
    end

    // R11: the cycle after a reset edge shows the idle output pair.
    always_ff @(posedge clk) begin
        if (rst_d) begin
            a_r11_reset_idle: assert (!q_o && q_n_o)
                else $error("a_r11_reset_idle");
        end
    end

    // R1: a detected trigger always leaves the output high on the next cycle.
    a_r1_fire_raises: assert property (@(posedge clk) disable iff (rst)
        fire |=> q_o);

    // R4: a low synchronized clear leaves the output low on the next cycle.
    a_r4_clear_idles: assert property (@(posedge clk) disable iff (rst)
        !clr_s |=> !q_o);

    // R6: the output only rises one cycle after a detected trigger.
    a_r6_rise_needs_fire: assert property (@(posedge clk) disable iff (rst)
        $rose(q_o) |-> $past(fire));

endmodule

bind pulse_oneshot oneshot_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .fire  (fire),
    .clr_s (clr_s),
    .q_o   (q_o),
    .q_n_o (q_n_o)
);

// File: tb/test_pulse_oneshot.sv
module test_pulse_oneshot;

    localparam int CLK_PERIOD = 10;
    localparam int DUR_W      = 16;
    localparam int WATCHDOG   = 50000;

    logic             clk   = 1'b0;
    logic             rst   = 1'b1;
    logic             a_n   = 1'b1;
    logic             b     = 1'b0;
    logic             clr_n = 1'b1;
    logic [DUR_W-1:0] dur   = '0;
    logic             q;
    logic             qn;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_oneshot #(.DUR_W(DUR_W), .SYNC_STAGES(2)) i_pulse_oneshot (
        .clk      (clk),
        .rst      (rst),
        .trig_n_i (a_n),
        .trig_i   (b),
        .clr_n_i  (clr_n),
        .dur_i    (dur),
        .q_o      (q),
        .q_n_o    (qn)
    );

    // Behavioural reference model.
    // Bit 0 of each history word holds the newest pin sample; the
    // conditions look at samples two and three edges old.
    bit [2:0] ha, hb, hc;
    int       rem;
    bit       m_ev;

    always @(posedge clk) begin
        if (rst) begin
            ha  = 3'b111;
            hb  = 3'b000;
            hc  = 3'b111;
            rem = 0;
        end else begin
            m_ev = hc[1] && ((!ha[1] && hb[1] && !hb[2]) ||
                             (hb[1] && !ha[1] && ha[2]) ||
                             (!ha[1] && hb[1] && !hc[2]));
            if (!hc[1])                 rem = 0;
            else if (m_ev && rem <= 1)  rem = (dur == 0) ? 1 : int'(dur);
            else if (rem > 0)           rem = rem - 1;
            ha = {ha[1:0], a_n};
            hb = {hb[1:0], b};
            hc = {hc[1:0], clr_n};
        end
    end

    // Compare the outputs with the model on every cycle, away from the edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (q !== (rem > 0)) begin
                errors++;
                $display("FAIL R8 model compare at %0t: q actual %0b expected %0b", $time, q, rem > 0);
            end
            checks++;
            if (qn !== ~q) begin
                errors++;
                $display("FAIL R7 complement at %0t: q_n actual %0b expected %0b", $time, qn, ~q);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_window(input int n, input string req);
        repeat (n) begin
            tick(1);
            chk(req, q, 1'b0);
        end
    endtask

    // Counts consecutive high samples, starting with the current one.
    task automatic count_high(output int n);
        n = 0;
        while (q === 1'b1 && n < 1000) begin
            n++;
            tick(1);
        end
    endtask

    int len;

    initial begin
        dur = 16'd5;
        tick(3);
        chk("R11 reset q", q, 1'b0);
        chk("R11 reset q_n", qn, 1'b1);
        rst = 1'b0;
        tick(4);

        // R6: trigger edges blocked by an idle enable level
        b = 1'b1;   idle_window(4, "R6 B rise with A high");
        b = 1'b0;   idle_window(4, "R6 B fall with A high");
        a_n = 1'b0; idle_window(4, "R6 A fall with B low");
        a_n = 1'b1; idle_window(4, "R6 A rise with B low");
        a_n = 1'b0; idle_window(4, "R6 A low B low");

        // R1 with the R10 latency and the R8 length
        dur = 16'd5;
        b = 1'b1;
        tick(2); chk("R10 no output before third edge", q, 1'b0);
        tick(1); chk("R1 B rise starts pulse", q, 1'b1);
        count_high(len); chk_int("R8 length 5", len, 5);

        // R2
        a_n = 1'b1; idle_window(4, "R2 A rise ignored");
        dur = 16'd3;
        a_n = 1'b0;
        tick(2); chk("R10 A path latency", q, 1'b0);
        tick(1); chk("R2 A fall starts pulse", q, 1'b1);
        count_high(len); chk_int("R8 length 3", len, 3);

        // R4 then R3, with a zero duration
        clr_n = 1'b0; idle_window(5, "R4 clear low holds idle");
        b = 1'b0; tick(1); b = 1'b1; idle_window(4, "R4 B rise under clear");
        dur = '0;
        clr_n = 1'b1;
        tick(2); chk("R10 clear path latency", q, 1'b0);
        tick(1); chk("R3 clear rise starts pulse", q, 1'b1);
        count_high(len); chk_int("R8 zero duration gives 1", len, 1);

        // R5: clear cuts a long pulse
        dur = 16'd20;
        b = 1'b0; tick(2); b = 1'b1;
        tick(3); chk("R1 pulse before clear", q, 1'b1);
        tick(4);
        clr_n = 1'b0;
        tick(2); chk("R10 clear takes three edges", q, 1'b1);
        tick(1); chk("R5 clear ends pulse", q, 1'b0);
        a_n = 1'b1; idle_window(5, "R5 stays low after clear");
        clr_n = 1'b1; idle_window(5, "R6 clear rise with A high");

        // R9: no retrigger, no extension
        dur = 16'd8;
        b = 1'b0; tick(2);
        a_n = 1'b0; tick(3);
        b = 1'b1;
        tick(3); chk("R1 pulse for retrigger test", q, 1'b1);
        tick(1); b = 1'b0;
        tick(1); b = 1'b1;
        count_high(len); chk_int("R9 retrigger ignored", len, 6);
        idle_window(6, "R9 no late pulse");

        // R12: trigger in the final cycle chains a new pulse
        dur = 16'd4;
        b = 1'b0; tick(2);
        b = 1'b1;
        tick(3); chk("R1 first pulse of chain", q, 1'b1);
        a_n = 1'b1;
        tick(1);
        a_n = 1'b0;
        count_high(len); chk_int("R12 chained pulse 4+4", len, 7);

        // Random phase checked by the model
        for (int i = 0; i < 3000; i++) begin
            a_n   = 1'($urandom % 2);
            b     = 1'($urandom % 2);
            clr_n = ($urandom % 8) != 0;
            dur   = 16'($urandom % 6);
            tick(1 + int'($urandom % 3));
        end

        tick(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule